// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Writes

A behavioural, synthesizable model of a single-port synchronous static RAM, 32 bits wide, built for short linear bursts of four words. Every control, address and data input is sampled on the rising clock edge. A burst begins when either of two address strobes loads a new external address. The processor-side strobe counts only while the first chip enable is active and always starts a read. The controller-side strobe reads or writes according to the write controls. After the load, a two-bit counter supplies the low address bits, and an advance input either steps that counter or holds it for a wait cycle.

Writes go through four byte lanes, each with its own strobe and a shared byte-write enable, or through a global write that covers the whole word. Three chip enables are sampled only when an address loads, and the selection they give is kept until the next load. Output enable is asynchronous. The data bus is split into an input, an output and a drive-enable. The depth is set by a parameter. The default is kept small for elaboration, and a 16-bit address gives the full 64K words.

Top module: `sburst_sram`

## Requirements
- R1: After reset, dq_oe_o is 0 and dq_o is all zeros until a selected read has been registered.
- R2: With adsp_ni=0 and ce_a_ni=0 at an edge, addr_i is loaded and a read of that address is performed, whatever gw_ni, bwe_ni and bw_ni are. The array is not written in that cycle.
- R3: With adsc_ni=0 and no processor-strobe load, addr_i is loaded. If gw_ni=0, or if bwe_ni=0 with any bw_ni bit at 0, the data on dq_i is written to that address at the same edge. Otherwise the address is read.
- R4: When adsp_ni=0, adsc_ni=0 and ce_a_ni=0 in the same cycle, the processor strobe wins: the cycle is a read and nothing is written.
- R5: adsp_ni=0 with ce_a_ni=1 and adsc_ni=1 loads nothing. The burst address and the selection are kept.
- R6: Without a load, adv_ni=0 steps the two low address bits linearly, modulo 4 (for example 2,3,0,1), and leaves the upper bits unchanged. A read or write in that cycle uses the stepped address.
- R7: Without a load, adv_ni=1 is a wait cycle. The address is unchanged, and a read repeats the same word.
- R8: With bwe_ni=0 and gw_ni=1, each bw_ni[k]=0 writes bits 8k+7:8k of dq_i, and lanes with bw_ni[k]=1 keep their old contents.
- R9: With bwe_ni=1 and gw_ni=1, bw_ni has no effect and the cycle is a read.
- R10: gw_ni=0 writes all 32 bits, whatever bwe_ni and bw_ni are (except in a processor-strobe cycle, R2).
- R11: The device is selected only when a load sees ce_a_ni=0, ce_b_ni=0 and ce_c_i=1. The chip enables are ignored in cycles without a load. While the device is deselected, no write takes effect and dq_oe_o stays 0.
- R12: dq_oe_o is 1 only when oe_ni=0, the last edge registered a selected read, and no write control is asserted on the current inputs (gw_ni=0, or bwe_ni=0 with any bw_ni bit 0). oe_ni and the write controls act without a clock edge.
- R13: Read data appears on dq_o one clock after its address is registered. Before that edge, dq_o keeps the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| adsp_ni | input | 1 | Processor-side address strobe, active low |
| adsc_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce_a_ni | input | 1 | Chip enable, active low, also qualifies adsp_ni |
| ce_b_ni | input | 1 | Chip enable, active low |
| ce_c_i | input | 1 | Chip enable, active high |
| gw_ni | input | 1 | Global 32-bit write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bw_ni | input | 4 | Per-lane byte-write strobes, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 32 | Write data |
| dq_o | output | 32 | Registered read data |
| dq_oe_o | output | 1 | Output drive enable |

## Verification
Full-word writes through the controller strobe fill known words. Reads through the processor strobe then show whether the load, the one-cycle latency and data integrity are right. A processor strobe carrying a global write, and both strobes asserted at once, show whether strobe priority and write suppression hold. A load at low bits 2 followed by four advances separates linear wrap from an off-by-one or a carry into the upper bits, and an advance-then-hold pattern separates a wait cycle from a step. Byte-lane masks with one lane and with two non-adjacent lanes, a masked write with the byte enable off, and a global write with all lane strobes off separate lane decoding from the override paths. Deselection through each enable, write attempts while deselected, and enable changes between loads show that the enables are sampled only at a load.

// File: rtl/sburst_pkg.sv
package sburst_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DATA_W = LANES * LANE_W;
  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/sburst_addr_ctl.sv
module sburst_addr_ctl #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_ni,
  input  logic              adsc_ni,
  input  logic              adv_ni,
  input  logic              ce_a_ni,
  input  logic              ce_b_ni,
  input  logic              ce_c_i,
  output logic [ADDR_W-1:0] addr_n_o,
  output logic              sel_n_o,
  output logic              load_p_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic              sel_q_o
);
  logic load_p, load_c, load, ce_ok;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic sel_q, sel_n;

  // processor strobe only counts with ce_a active and takes priority
  assign load_p = ~adsp_ni & ~ce_a_ni;
  assign load_c = ~adsc_ni & ~load_p;
  assign load   = load_p | load_c;
  assign ce_ok  = ~ce_a_ni & ~ce_b_ni & ce_c_i;

  always_comb begin
    addr_n = addr_q;
    if (load) begin
      addr_n = addr_i;
    end else if (!adv_ni) begin
      addr_n[1:0] = addr_q[1:0] + 2'd1;
    end
  end

  assign sel_n = load ? ce_ok : sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      addr_q <= addr_n;
      sel_q  <= sel_n;
    end
  end

  assign addr_n_o = addr_n;
  assign sel_n_o  = sel_n;
  assign load_p_o = load_p;
  assign addr_q_o = addr_q;
  assign sel_q_o  = sel_q;
endmodule

// File: rtl/sburst_byte_mask.sv
module sburst_byte_mask
  import sburst_pkg::*;
(
  input  logic       gw_ni,
  input  logic       bwe_ni,
  input  lane_mask_t bw_ni,
  output lane_mask_t lane_we_o,
  output logic       wr_any_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_we_o[k] = ~gw_ni | (~bwe_ni & ~bw_ni[k]);
  end
  assign wr_any_o = |lane_we_o;
endmodule

// File: rtl/sburst_array.sv
module sburst_array
  import sburst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  lane_mask_t        lane_we_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  word_t             din_i,
  output word_t             dout_o,
  output logic              rd_valid_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (wr_en_i && lane_we_i[k]) mem[addr_i] <= din_i[k*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rd_q <= '0;
      else if (rd_en_i) rd_q <= mem[addr_i];
    end

    assign dout_o[k*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_o <= 1'b0;
    else         rd_valid_o <= rd_en_i;
  end
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
  import sburst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_ni,
  input  logic              adsc_ni,
  input  logic              adv_ni,
  input  logic              ce_a_ni,
  input  logic              ce_b_ni,
  input  logic              ce_c_i,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic [ADDR_W-1:0] addr_n, addr_q;
  logic              sel_n, sel_q, load_p;
  lane_mask_t        lane_we;
  logic              wr_any, wr_en, rd_en, rd_valid;

  sburst_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .adsp_ni  (adsp_ni),
    .adsc_ni  (adsc_ni),
    .adv_ni   (adv_ni),
    .ce_a_ni  (ce_a_ni),
    .ce_b_ni  (ce_b_ni),
    .ce_c_i   (ce_c_i),
    .addr_n_o (addr_n),
    .sel_n_o  (sel_n),
    .load_p_o (load_p),
    .addr_q_o (addr_q),
    .sel_q_o  (sel_q)
  );

  sburst_byte_mask u_mask (
    .gw_ni     (gw_ni),
    .bwe_ni    (bwe_ni),
    .bw_ni     (bw_ni),
    .lane_we_o (lane_we),
    .wr_any_o  (wr_any)
  );

  // processor-strobe cycles are always reads
  assign wr_en = sel_n & ~load_p & wr_any;
  assign rd_en = sel_n & ~wr_en;

  sburst_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_n),
    .lane_we_i  (lane_we),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .din_i      (dq_i),
    .dout_o     (dq_o),
    .rd_valid_o (rd_valid)
  );

  assign dq_oe_o = ~oe_ni & rd_valid & ~wr_any;
endmodule

// File: rtl/sburst_sram_chk.sv
module sburst_sram_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              adsp_ni,
  input logic              adsc_ni,
  input logic              adv_ni,
  input logic              ce_a_ni,
  input logic              gw_ni,
  input logic              oe_ni,
  input logic              dq_oe_o,
  input logic [ADDR_W-1:0] addr_q,
  input logic              sel_q
);
  logic p_load, no_load;
  assign p_load  = ~adsp_ni & ~ce_a_ni;
  assign no_load = ~p_load & adsc_ni;

  AST_PSTROBE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_load |=> addr_q == $past(addr_i)); // R2
  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_load && !adv_ni) |=> addr_q[1:0] == $past(addr_q[1:0]) + 2'd1); // R6
  AST_BURST_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_load |=> $stable(addr_q[ADDR_W-1:2])); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_load && adv_ni) |=> $stable(addr_q)); // R7
  AST_SEL_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_load |=> $stable(sel_q)); // R11
  AST_DESEL_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_q |-> !dq_oe_o); // R11
  AST_OE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o); // R12
  AST_GW_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gw_ni |-> !dq_oe_o); // R12
endmodule

bind sburst_sram sburst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .adsp_ni (adsp_ni),
  .adsc_ni (adsc_ni),
  .adv_ni  (adv_ni),
  .ce_a_ni (ce_a_ni),
  .gw_ni   (gw_ni),
  .oe_ni   (oe_ni),
  .dq_oe_o (dq_oe_o),
  .addr_q  (addr_q),
  .sel_q   (sel_q)
);

// File: tb/sburst_sram_test.sv
module sburst_sram_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]  addr_i;
  logic        adsp_ni, adsc_ni, adv_ni, ce_a_ni, ce_b_ni, ce_c_i;
  logic        gw_ni, bwe_ni, oe_ni;
  logic [3:0]  bw_ni;
  logic [31:0] dq_i, dq_o;
  logic        dq_oe_o;

  logic [31:0] model [256];
  int checks = 0, errors = 0;
  bit done = 0;

  sburst_sram #(.ADDR_W(8)) uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle_in();
    adsp_ni = 1; adsc_ni = 1; adv_ni = 1;
    gw_ni = 1; bwe_ni = 1; bw_ni = 4'hF;
  endtask

  task automatic sel_ce();
    ce_a_ni = 0; ce_b_ni = 0; ce_c_i = 1;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic wr_word(logic [7:0] a, logic [31:0] d);
    idle_in(); sel_ce();
    addr_i = a; adsc_ni = 0; gw_ni = 0; dq_i = d;
    tick(); idle_in();
    model[a] = d;
  endtask

  task automatic rd_word(string tag, logic [7:0] a);
    idle_in(); sel_ce();
    addr_i = a; adsp_ni = 0;
    tick(); idle_in(); #1;
    chk({tag, " oe"}, {31'd0, dq_oe_o}, 32'd1);
    chk({tag, " data"}, dq_o, model[a]);
  endtask

  task automatic t_reset();
    chk("R1 oe after reset", {31'd0, dq_oe_o}, 32'd0);
    chk("R1 dq after reset", dq_o, 32'd0);
  endtask

  task automatic t_basic();
    for (int i = 0; i < 4; i++) wr_word(8'h10 + 8'(i), 32'hA0B0_0000 + 32'(i * 17));
    wr_word(8'h50, 32'h5050_5050);
    wr_word(8'h60, 32'h6060_0606);
    rd_word("R3 write then read", 8'h11);
    rd_word("R2 pstrobe read", 8'h13);
  endtask

  task automatic t_latency();
    rd_word("R13 first", 8'h10);
    addr_i = 8'h11; adsp_ni = 0; #1;
    chk("R13 before edge", dq_o, model[8'h10]);
    tick(); idle_in(); #1;
    chk("R13 after edge", dq_o, model[8'h11]);
  endtask

  task automatic t_pstrobe_nowrite();
    idle_in(); sel_ce();
    addr_i = 8'h60; adsp_ni = 0; gw_ni = 0; bwe_ni = 0; bw_ni = 4'h0; dq_i = 32'hDEAD_BEEF;
    tick(); idle_in(); #1;
    chk("R2 pstrobe with write ctrl reads", dq_o, model[8'h60]);
    rd_word("R2 array unchanged", 8'h60);
  endtask

  task automatic t_priority();
    idle_in(); sel_ce();
    addr_i = 8'h60; adsp_ni = 0; adsc_ni = 0; gw_ni = 0; dq_i = 32'hBAD0_BAD0;
    tick(); idle_in(); #1;
    chk("R4 both strobes read", dq_o, model[8'h60]);
    chk("R4 both strobes oe", {31'd0, dq_oe_o}, 32'd1);
    rd_word("R4 no write", 8'h60);
  endtask

  task automatic t_burst_read();
    rd_word("R6 load low bits 2", 8'h12);
    for (int i = 1; i <= 4; i++) begin
      adv_ni = 0;
      tick(); #1;
      chk($sformatf("R6 burst step %0d", i), dq_o, model[8'h10 + 8'((2 + i) % 4)]);
    end
    idle_in();
  endtask

  task automatic t_burst_write();
    idle_in(); sel_ce();
    addr_i = 8'h21; adsc_ni = 0; gw_ni = 0; dq_i = 32'hC000_0001;
    tick();
    adsc_ni = 1; adv_ni = 0;
    dq_i = 32'hC000_0002; tick();
    dq_i = 32'hC000_0003; tick();
    dq_i = 32'hC000_0004; tick();
    idle_in();
    model[8'h21] = 32'hC000_0001; model[8'h22] = 32'hC000_0002;
    model[8'h23] = 32'hC000_0003; model[8'h20] = 32'hC000_0004;
    rd_word("R6 burst write wrap 20", 8'h20);
    rd_word("R6 burst write 23", 8'h23);
  endtask

  task automatic t_hold();
    rd_word("R7 load", 8'h12);
    tick(); #1;
    chk("R7 wait 1", dq_o, model[8'h12]);
    tick(); #1;
    chk("R7 wait 2", dq_o, model[8'h12]);
    adv_ni = 0; tick(); idle_in(); #1;
    chk("R7 advance after wait", dq_o, model[8'h13]);
  endtask

  task automatic t_bytes();
    wr_word(8'h30, 32'h1122_3344);
    idle_in(); sel_ce();
    addr_i = 8'h30; adsc_ni = 0; bwe_ni = 0; bw_ni = 4'b1011; dq_i = 32'hAABB_CCDD;
    tick(); idle_in();
    model[8'h30] = 32'h11BB_3344;
    rd_word("R8 lane 2 only", 8'h30);
    addr_i = 8'h30; adsp_ni = 1; adsc_ni = 0; bwe_ni = 0; bw_ni = 4'b0110;
    tick(); idle_in();
    model[8'h30] = 32'hAABB_33DD;
    rd_word("R8 lanes 0 and 3", 8'h30);
    addr_i = 8'h30; adsc_ni = 0; bwe_ni = 1; bw_ni = 4'h0; dq_i = 32'h0;
    tick(); idle_in(); #1;
    chk("R9 bw ignored, reads", dq_o, model[8'h30]);
    rd_word("R9 array unchanged", 8'h30);
    addr_i = 8'h30; adsc_ni = 0; gw_ni = 0; bwe_ni = 1; bw_ni = 4'hF; dq_i = 32'h9876_5432;
    tick(); idle_in();
    model[8'h30] = 32'h9876_5432;
    rd_word("R10 global write", 8'h30);
  endtask

  task automatic t_select();
    for (int i = 0; i < 4; i++) wr_word(8'h40 + 8'(i), 32'h4040_0000 + 32'(i));
    rd_word("R11 selected", 8'h40);
    addr_i = 8'h40; adsc_ni = 0; ce_c_i = 0;
    tick(); idle_in(); ce_c_i = 1; #1;
    chk("R11 deselect by ce_c", {31'd0, dq_oe_o}, 32'd0);
    adv_ni = 0; gw_ni = 0; dq_i = 32'hFFFF_0000;
    tick(); tick(); idle_in(); #1;
    chk("R11 enables ignored without load", {31'd0, dq_oe_o}, 32'd0);
    addr_i = 8'h40; adsp_ni = 0; ce_b_ni = 1;
    tick(); idle_in(); ce_b_ni = 0; #1;
    chk("R11 deselect by ce_b", {31'd0, dq_oe_o}, 32'd0);
    rd_word("R11 no write while deselected 41", 8'h41);
    rd_word("R11 no write while deselected 42", 8'h42);
    ce_c_i = 0; tick(); #1;
    chk("R11 kept selection", {31'd0, dq_oe_o}, 32'd1);
    chk("R11 kept selection data", dq_o, model[8'h42]);
    sel_ce();
  endtask

  task automatic t_no_load();
    rd_word("R5 base", 8'h50);
    addr_i = 8'h13; adsp_ni = 0; ce_a_ni = 1;
    tick(); idle_in(); ce_a_ni = 0; #1;
    chk("R5 gated strobe loads nothing", dq_o, model[8'h50]);
    chk("R5 selection kept", {31'd0, dq_oe_o}, 32'd1);
  endtask

  task automatic t_oe();
    rd_word("R12 base", 8'h11);
    oe_ni = 1; #1;
    chk("R12 oe high", {31'd0, dq_oe_o}, 32'd0);
    oe_ni = 0; #1;
    chk("R12 oe low", {31'd0, dq_oe_o}, 32'd1);
    gw_ni = 0; #1;
    chk("R12 gw hiz", {31'd0, dq_oe_o}, 32'd0);
    gw_ni = 1; bwe_ni = 0; bw_ni = 4'b1110; #1;
    chk("R12 byte write hiz", {31'd0, dq_oe_o}, 32'd0);
    idle_in(); #1;
    chk("R12 restored", {31'd0, dq_oe_o}, 32'd1);
  endtask

  initial begin
    idle_in(); sel_ce();
    oe_ni = 0; addr_i = '0; dq_i = '0;
    repeat (3) @(posedge clk_i);
    #3 rst_ni = 1;
    #1;
    t_reset();
    t_basic();
    t_latency();
    t_pstrobe_nowrite();
    t_priority();
    t_burst_read();
    t_burst_write();
    t_hold();
    t_bytes();
    t_select();
    t_no_load();
    t_oe();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule